// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the SCL waveform for an I2C master from a fast system clock. One clock-control count (`ccr`) sets both phases of the SCL period. A mode flag and a duty select then choose the ratio of low time to high time. In standard mode the two phases are equal. In fast mode the low phase is twice the high phase, or, with the duty select set, the low and high phases are 16 and 9 times the count.

The block drives SCL only through an open-drain pull-low request. It samples the real line back on `scl_in`, and the high phase starts counting only once the line is seen high. A slave that holds SCL low therefore stretches the clock for as long as it likes. If the line is still low after a programmable rise-time allowance, a sticky stretch flag is raised.

Three strobes mark the first low cycle, the first high cycle and the middle of the high phase. A sequencer for data, start and stop conditions uses them to time its SDA changes and its sampling. Count values that are too small are refused: the block raises an error flag and does not start a low phase. The count and mode inputs are taken only at each SCL falling edge, so reprogramming never produces a clipped pulse.

Top module: `scl_clk_gen`

## Requirements
- R1: Standard mode (`fast_mode`=0): SCL is held low for `ccr` clock cycles and released for `ccr` cycles on an unloaded bus, giving a period of 2×`ccr` (210 gives 420 cycles, which is 100 kHz from 42 MHz).
- R2: Fast mode with `duty_sel`=0: the low phase lasts 2×`ccr` cycles and the high phase `ccr` cycles (35 gives a 105-cycle period, 400 kHz from 42 MHz).
- R3: Fast mode with `duty_sel`=1: the low phase lasts 16×`ccr` cycles and the high phase 9×`ccr` cycles.
- R4: `ccr`, `fast_mode` and `duty_sel` are taken only when a low phase begins. A change during a period leaves that period's low and high lengths unchanged.
- R5: A count is illegal when it is below 4 in standard mode or 0 in fast mode. One cycle after an enabled illegal setting is presented, `cfg_err` is 1. While it is presented, no new low phase begins and SCL stays released.
- R6: The high phase counts only cycles in which `scl_in` is sampled high. While a slave holds SCL low after release, the low time grows without bound, and the high phase still lasts the full programmed length once the line goes high.
- R7: If `scl_in` is still low in the `trise`-th released cycle, `stretch_det` goes to 1 on the next cycle. It stays at 1 until `en` is deasserted.
- R8: One cycle after `en` is 0, `scl_pull_low`, `stretch_det` and `cfg_err` are all 0 and the phase counters are cleared. After reset all outputs are 0.
- R9: `fall_stb` is 1 in the first cycle of each low phase. `rise_stb` is 1 in the first cycle in which released SCL is sampled high. `mid_high_stb` is 1 in high cycle number ceil(H/2), where H is the high length. Each appears once per period.
- R10: With `en` newly 1 and a legal setting, the first low phase begins on the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the generator; 0 releases SCL |
| ccr | input | 12 | Clock-control count |
| fast_mode | input | 1 | 0 standard ratio, 1 fast ratio |
| duty_sel | input | 1 | Fast mode only: 0 for 2:1, 1 for 16:9 |
| trise | input | 8 | Rise-time allowance in clock cycles |
| scl_in | input | 1 | Sampled SCL line |
| scl_pull_low | output | 1 | Open-drain request to drive SCL low |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle SCL is seen high |
| mid_high_stb | output | 1 | Middle of the high phase |
| cfg_err | output | 1 | Illegal count presented while enabled |
| stretch_det | output | 1 | Sticky: SCL held low past the allowance |

## Verification
The assertions check the following on every cycle. Each strobe only occurs with the line in the matching level. A pull-low always begins with `fall_stb`. Disabling releases the line and clears the flags a cycle later. An illegal setting blocks any new low phase and raises `cfg_err`. The stretch flag only rises after a released-but-low cycle. The phase lengths for each mode and the 210 and 35 period examples can only be shown by the bench scenarios, as can the latching of settings at the falling edge, an unbounded stretch followed by a full high phase, and the 4-and-above boundary. A behavioural model compares every output on every cycle of those scenarios.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/scl_len_calc.sv
// Turns the count and mode selection into phase lengths and a legality flag.
module scl_len_calc #(
  parameter int CCR_W   = 12,
  parameter int CNT_W   = CCR_W + 5,
  parameter int MIN_STD = 4
) (
  input  logic [CCR_W-1:0] ccr,
  input  logic             fast_mode,
  input  logic             duty_sel,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] high_len,
  output logic [CNT_W-1:0] mid_len,
  output logic             illegal
);
  localparam logic [CCR_W-1:0] STD_FLOOR = CCR_W'(MIN_STD);

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] high_p1;

  assign base = CNT_W'(ccr);

  always_comb begin
    if (!fast_mode) begin
      low_len  = base;
      high_len = base;
    end else if (duty_sel) begin
      low_len  = base << 4;
      high_len = (base << 3) + base;
    end else begin
      low_len  = base << 1;
      high_len = base;
    end
  end

  assign high_p1 = high_len + CNT_W'(1);
  assign mid_len = high_p1 >> 1;
  assign illegal = fast_mode ? (ccr == '0) : (ccr < STD_FLOOR);
endmodule

// File: rtl/scl_phase_fsm.sv
// Phase sequencer: low, wait-for-high, high; settings latched at each fall.
module scl_phase_fsm
  import scl_div_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int TR_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             scl_in,
  input  logic             illegal,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] high_len,
  input  logic [CNT_W-1:0] mid_len,
  input  logic [TR_W-1:0]  trise,
  output logic             pull_low,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             mid_stb,
  output logic             stretch
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  scl_phase_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lo_q, lo_d;
  logic [CNT_W-1:0] hi_q, hi_d;
  logic [CNT_W-1:0] md_q, md_d;
  logic             str_q, str_d;
  logic             load, fall;
  logic [CNT_W-1:0] trise_w;
  logic [CNT_W-1:0] high_pos;
  logic             seen_high;

  assign trise_w = CNT_W'(trise);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    lo_d  = lo_q;
    hi_d  = hi_q;
    md_d  = md_q;
    str_d = str_q;
    load  = 1'b0;
    fall  = 1'b0;
    if (!en) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
      str_d = 1'b0;
    end else begin
      unique case (st_q)
        PH_IDLE: load = !illegal;
        PH_LOW: begin
          if (cnt_q >= lo_q) begin
            st_d  = PH_WAIT;
            cnt_d = ONE;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        PH_WAIT: begin
          if (scl_in) begin
            if (hi_q <= ONE) begin
              fall = 1'b1;
            end else begin
              st_d  = PH_HIGH;
              cnt_d = TWO;
            end
          end else begin
            if (cnt_q >= trise_w) str_d = 1'b1;
            if (cnt_q != '1) cnt_d = cnt_q + ONE;
          end
        end
        PH_HIGH: begin
          if (cnt_q >= hi_q) fall = 1'b1;
          else cnt_d = cnt_q + ONE;
        end
        default: st_d = PH_IDLE;
      endcase
      if (fall) begin
        if (illegal) begin
          st_d  = PH_IDLE;
          cnt_d = '0;
        end else begin
          load = 1'b1;
        end
      end
      if (load) begin
        st_d  = PH_LOW;
        cnt_d = ONE;
        lo_d  = low_len;
        hi_d  = high_len;
        md_d  = mid_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      md_q  <= '0;
      str_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      md_q  <= md_d;
      str_q <= str_d;
    end
  end

  assign seen_high = (st_q == PH_WAIT) && scl_in;
  assign high_pos  = seen_high ? ONE : cnt_q;
  assign pull_low  = (st_q == PH_LOW);
  assign fall_stb  = pull_low && (cnt_q == ONE);
  assign rise_stb  = seen_high;
  assign mid_stb   = (seen_high || (st_q == PH_HIGH)) && (high_pos == md_q);
  assign stretch   = str_q;
endmodule

// File: rtl/scl_clk_gen.sv
// Top: reset release synchroniser, length calculator, phase sequencer, error flag.
module scl_clk_gen #(
  parameter int CCR_W   = 12,
  parameter int TR_W    = 8,
  parameter int MIN_STD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CCR_W-1:0] ccr,
  input  logic             fast_mode,
  input  logic             duty_sel,
  input  logic [TR_W-1:0]  trise,
  input  logic             scl_in,
  output logic             scl_pull_low,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             mid_high_stb,
  output logic             cfg_err,
  output logic             stretch_det
);
  localparam int CNT_W = CCR_W + 5;

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic [CNT_W-1:0] low_len, high_len, mid_len;
  logic             illegal;
  logic             err_d, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  scl_len_calc #(
    .CCR_W(CCR_W), .CNT_W(CNT_W), .MIN_STD(MIN_STD)
  ) u_len (
    .ccr(ccr), .fast_mode(fast_mode), .duty_sel(duty_sel),
    .low_len(low_len), .high_len(high_len), .mid_len(mid_len),
    .illegal(illegal)
  );

  scl_phase_fsm #(
    .CNT_W(CNT_W), .TR_W(TR_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n_int), .en(en), .scl_in(scl_in),
    .illegal(illegal), .low_len(low_len), .high_len(high_len),
    .mid_len(mid_len), .trise(trise),
    .pull_low(scl_pull_low), .fall_stb(fall_stb), .rise_stb(rise_stb),
    .mid_stb(mid_high_stb), .stretch(stretch_det)
  );

  assign err_d = en && illegal;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) err_q <= 1'b0;
    else            err_q <= err_d;
  end
  assign cfg_err = err_q;
endmodule

// File: rtl/scl_clk_gen_chk.sv
module scl_clk_gen_chk #(
  parameter int CCR_W   = 12,
  parameter int MIN_STD = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [CCR_W-1:0] ccr,
  input logic             fast_mode,
  input logic             scl_in,
  input logic             scl_pull_low,
  input logic             fall_stb,
  input logic             rise_stb,
  input logic             mid_high_stb,
  input logic             cfg_err,
  input logic             stretch_det
);
  logic bad_cfg;
  assign bad_cfg = fast_mode ? (ccr == '0) : (ccr < CCR_W'(MIN_STD));

  // R8: disabling releases SCL and clears both flags one cycle later
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_pull_low && !stretch_det && !cfg_err));

  // R5: an illegal count never begins a low phase
  a_r5_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bad_cfg) |=> !fall_stb);

  // R5: an illegal count raises the error flag
  a_r5_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bad_cfg) |=> cfg_err);

  // R9: the fall strobe coincides with the pull-low request
  a_r9_fall_pull: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> scl_pull_low);

  // R9: every new pull-low is marked by the fall strobe
  a_r9_pull_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_low) |-> fall_stb);

  // R6: the rise strobe only with SCL released and sampled high
  a_r6_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (!scl_pull_low && scl_in));

  // R9: the mid-high strobe only while SCL is high
  a_r9_mid_high: assert property (@(posedge clk) disable iff (!rst_n)
    mid_high_stb |-> (!scl_pull_low && scl_in));

  // R9: the two edge strobes never coincide
  a_r9_edge_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_stb, rise_stb}));

  // R7: the stretch flag rises only after a released cycle with SCL low
  a_r7_stretch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stretch_det) |-> $past(en && !scl_pull_low && !scl_in));
endmodule

bind scl_clk_gen scl_clk_gen_chk #(.CCR_W(CCR_W), .MIN_STD(MIN_STD)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ccr(ccr), .fast_mode(fast_mode),
  .scl_in(scl_in), .scl_pull_low(scl_pull_low), .fall_stb(fall_stb),
  .rise_stb(rise_stb), .mid_high_stb(mid_high_stb), .cfg_err(cfg_err),
  .stretch_det(stretch_det)
);

// File: tb/scl_clk_gen_tb_top.sv
module scl_clk_gen_tb_top;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic [11:0] ccr;
  logic        fast_mode;
  logic        duty_sel;
  logic [7:0]  trise;
  logic        hold;
  logic        scl_line;
  logic        scl_pull_low, fall_stb, rise_stb, mid_high_stb, cfg_err, stretch_det;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  assign scl_line = !(scl_pull_low || hold);

  scl_clk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .ccr(ccr), .fast_mode(fast_mode),
    .duty_sel(duty_sel), .trise(trise), .scl_in(scl_line),
    .scl_pull_low(scl_pull_low), .fall_stb(fall_stb), .rise_stb(rise_stb),
    .mid_high_stb(mid_high_stb), .cfg_err(cfg_err), .stretch_det(stretch_det)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lo_of(int c, bit f, bit d);
    return !f ? c : (d ? 16 * c : 2 * c);
  endfunction
  function automatic int hi_of(int c, bit f, bit d);
    return !f ? c : (d ? 9 * c : c);
  endfunction
  function automatic bit bad_of(int c, bit f);
    return f ? (c == 0) : (c < 4);
  endfunction

  // Behavioural reference: phase 0 idle, 1 low (cnt = cycles left), 2 waiting
  // for high (cnt = released cycles), 3 high (cnt = high cycle number).
  int m_ph = 0, m_cnt = 0, m_lo = 0, m_hi = 0;
  bit m_str = 0, m_err = 0;

  task automatic m_start();
    if (bad_of(int'(ccr), fast_mode)) begin
      m_ph = 0;
    end else begin
      m_lo = lo_of(int'(ccr), fast_mode, duty_sel);
      m_hi = hi_of(int'(ccr), fast_mode, duty_sel);
      m_ph = 1;
      m_cnt = m_lo;
    end
  endtask

  always @(posedge clk) begin
    bit bus;
    bus = (m_ph != 1) && !hold;
    if (!rst_n) begin
      m_ph = 0; m_str = 0; m_err = 0; m_cnt = 0;
    end else begin
      m_err = en && bad_of(int'(ccr), fast_mode);
      if (!en) begin
        m_ph = 0; m_str = 0; m_cnt = 0;
      end else begin
        case (m_ph)
          0: m_start();
          1: if (m_cnt == 1) begin m_ph = 2; m_cnt = 1; end else m_cnt--;
          2: if (bus) begin
               if (m_hi == 1) m_start();
               else begin m_ph = 3; m_cnt = 2; end
             end else begin
               if (m_cnt >= int'(trise)) m_str = 1;
               m_cnt++;
             end
          default: if (m_cnt >= m_hi) m_start(); else m_cnt++;
        endcase
      end
    end
  end

  always begin
    @(negedge clk);
    #1;
    if (rst_n && !done) begin
      bit bus, hs;
      int hp;
      bus = (m_ph != 1) && !hold;
      hs = (m_ph == 2 && bus) || m_ph == 3;
      hp = (m_ph == 2) ? 1 : m_cnt;
      chk("R1 model scl_pull_low", int'(scl_pull_low), int'(m_ph == 1));
      chk("R9 model fall_stb", int'(fall_stb), int'(m_ph == 1 && m_cnt == m_lo));
      chk("R9 model rise_stb", int'(rise_stb), int'(m_ph == 2 && bus));
      chk("R9 model mid_high_stb", int'(mid_high_stb), int'(hs && hp == (m_hi + 1) / 2));
      chk("R5 model cfg_err", int'(cfg_err), int'(m_err));
      chk("R7 model stretch_det", int'(stretch_det), int'(m_str));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R1 watchdog actual %0d expected below %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Starts at a negedge showing fall_stb; returns at the next one.
  task automatic measure(input string tag, input int exp_lo, input int exp_hi);
    int lo = 0, hi = 0, mids = 0, rises = 0;
    while (!fall_stb) @(negedge clk);
    while (scl_pull_low) begin lo++; @(negedge clk); end
    do begin
      hi++;
      mids += int'(mid_high_stb);
      rises += int'(rise_stb);
      @(negedge clk);
    end while (!fall_stb && hi < 20000);
    chk({tag, " low length"}, lo, exp_lo);
    chk({tag, " high length"}, hi, exp_hi);
    chk("R9 mid_high_stb per period", mids, 1);
    chk("R9 rise_stb per period", rises, 1);
  endtask

  initial begin
    int pulls;
    rst_n = 0; en = 0; ccr = 12'd210; fast_mode = 0; duty_sel = 0;
    trise = 8'd43; hold = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R8 reset scl_pull_low", int'(scl_pull_low), 0);
    chk("R8 reset cfg_err", int'(cfg_err), 0);
    chk("R8 reset stretch_det", int'(stretch_det), 0);

    // R10: first low phase on the next cycle
    en = 1;
    @(negedge clk);
    chk("R10 start fall_stb", int'(fall_stb), 1);
    chk("R10 start scl_pull_low", int'(scl_pull_low), 1);
    measure("R1 std 210", 210, 210);
    // R4: switch to fast 35 at the start of a period; this period stays 210/210
    fast_mode = 1; ccr = 12'd35; trise = 8'd14;
    measure("R4 latched old setting", 210, 210);
    measure("R2 fast 35", 70, 35);
    duty_sel = 1; ccr = 12'd5;
    measure("R4 latched fast 35", 70, 35);
    measure("R3 duty 16:9", 80, 45);
    duty_sel = 0; ccr = 12'd1;
    measure("R4 latched duty", 80, 45);
    measure("R2 fast minimum 1", 2, 1);

    // R6 / R7: slave stretches SCL
    fast_mode = 0; ccr = 12'd10; trise = 8'd4;
    measure("R4 latched fast 1", 2, 1);
    measure("R1 std 10", 10, 10);
    hold = 1;
    repeat (40) @(negedge clk);
    chk("R6 held low no rise_stb", int'(rise_stb), 0);
    chk("R7 stretch_det raised", int'(stretch_det), 1);
    chk("R6 released while held", int'(scl_pull_low), 0);
    hold = 0;
    begin
      int hi = 0;
      do begin hi++; @(negedge clk); end while (!fall_stb && hi < 1000);
      chk("R6 full high after stretch", hi, 10);
    end
    chk("R7 stretch_det sticky", int'(stretch_det), 1);
    // R8: disable in the middle of a low phase
    @(negedge clk);
    en = 0;
    @(negedge clk);
    chk("R8 disable releases SCL", int'(scl_pull_low), 0);
    chk("R8 disable clears stretch_det", int'(stretch_det), 0);

    // R5: illegal counts
    ccr = 12'd3; en = 1;
    pulls = 0;
    repeat (30) begin @(negedge clk); pulls += int'(scl_pull_low); end
    chk("R5 std 3 no pulls", pulls, 0);
    chk("R5 std 3 cfg_err", int'(cfg_err), 1);
    ccr = 12'd4;
    @(negedge clk);
    chk("R10 restart at std 4", int'(fall_stb), 1);
    chk("R5 std 4 clears cfg_err", int'(cfg_err), 0);
    measure("R1 std minimum 4", 4, 4);
    fast_mode = 1; ccr = 12'd0;
    pulls = 0;
    @(negedge clk);
    while (scl_pull_low || fall_stb) @(negedge clk);
    repeat (20) begin @(negedge clk); pulls += int'(scl_pull_low); end
    chk("R5 fast 0 no pulls", pulls, 0);
    chk("R5 fast 0 cfg_err", int'(cfg_err), 1);
    en = 0;
    @(negedge clk);
    chk("R8 disable clears cfg_err", int'(cfg_err), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule